// File: doc/BRIEF.md
# Shadowed SRAM Store/Recall Controller

This block is a byte-wide working memory of 2048 words in which every word has a non-volatile shadow copy. The memory is driven through a synchronous bus with a memory select, a read strobe, a write strobe, an 11-bit address and 8-bit write and read data. A separate non-volatile mode input chooses between plain random access and whole-array transfers between the working array and the shadow array.

A STORE copies every working word into the shadow array. A RECALL runs in two passes: it first zeroes the whole working array, then copies the shadow array into it. While either transfer runs, the `xfer_busy` output is high, the read port is silent and bus writes are dropped. Transfers move one word per clock in ascending address order. A STORE then holds `xfer_busy` for a set number of extra cycles, which stands in for the programming time. A RECALL also starts by itself when reset is released. The shadow array is never reset, so its contents survive a reset.

Top module: `shadowed_sram`

## Requirements
- R1: With `nv_mode` low and `xfer_busy` low, a clock edge at which `mem_sel` and `wr_en` are both high writes `bus_wdata` into the working word at `bus_addr`.
- R2: With `nv_mode`, `xfer_busy` and `wr_en` low, a clock edge at which `mem_sel` and `rd_en` are high makes `bus_rdata_vld` high and `bus_rdata` equal to the addressed word for the following cycle. In all other cycles `bus_rdata_vld` is low and `bus_rdata` is zero.
- R3: While `nv_mode` is high, no bus read returns data and no bus write changes the working array.
- R4: A STORE starts when `mem_sel`, `wr_en` and `nv_mode` are high together at a clock edge. It copies words 0 to 2047 into the shadow array, one per clock, and keeps `xfer_busy` high for exactly 2048 + STORE_WAIT cycles (STORE_WAIT defaults to 16).
- R5: A RECALL starts when `mem_sel`, `rd_en` and `nv_mode` are high and `wr_en` is low at a clock edge. It clears all working words and then loads them from the shadow array. `xfer_busy` stays high for exactly 4096 cycles, and afterwards every working word equals its shadow word.
- R6: A RECALL leaves the shadow array unchanged, so repeated RECALLs give the same working contents.
- R7: Bus writes in normal mode never change the shadow array.
- R8: While `xfer_busy` is high, `bus_rdata_vld` is low, `bus_rdata` is zero and bus writes are ignored.
- R9: After a transfer has started, no further transfer starts until the bus has left the trigger condition for at least one clock.
- R10: After `rst_n` is released, a RECALL runs by itself. `xfer_busy` falls 4098 cycles after the release: 2 cycles of reset synchronisation plus 4096 cycles of transfer.
- R11: While `rst_n` is low, `xfer_busy` is high, `bus_rdata_vld` is low and `bus_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_sel | input | 1 | Memory select |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| nv_mode | input | 1 | High selects non-volatile transfer mode |
| bus_addr | input | 11 | Word address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, zero when not valid |
| bus_rdata_vld | output | 1 | Read data valid |
| xfer_busy | output | 1 | STORE or RECALL in progress |

## Verification
The bench writes a word after a STORE and then recalls. A design that let bus writes reach the shadow array would return the newer value instead of the stored one. It holds the STORE trigger across the whole transfer to catch a controller that starts again on a level, and while the trigger is held it offers a write to show that non-volatile mode blocks writes. During a STORE it issues bus writes and reads: a leaky lockout would corrupt a word or raise the valid flag. It also counts the busy cycles of STORE, RECALL and the reset-time RECALL, and after a reset it checks that the stored data comes back and that unstored data written before the reset does not.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

  typedef enum logic [2:0] {
    XS_IDLE  = 3'd0,
    XS_STORE = 3'd1,
    XS_HOLD  = 3'd2,
    XS_CLEAR = 3'd3,
    XS_LOAD  = 3'd4
  } xfer_state_e;

endpackage

// File: rtl/ssr_word_array.sv
module ssr_word_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  // Storage carries no reset: contents persist across reset.
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_q[wr_addr] <= wr_data;
    end
  end

  assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/ssr_bus_ctrl.sv
module ssr_bus_ctrl #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mem_sel,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic              nv_mode,
  input  logic              busy,
  input  logic [DATA_W-1:0] work_rd_data,
  output logic              store_go,
  output logic              recall_go,
  output logic              sram_wr,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_vld
);

  logic              armed_q, armed_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              vld_q, vld_d;
  logic              trig, start_ok, rd_req;

  // Decode of the bus in normal mode
  assign sram_wr = mem_sel & wr_en & ~nv_mode & ~busy;
  assign rd_req  = mem_sel & rd_en & ~wr_en & ~nv_mode & ~busy;

  // Transfer trigger: the write strobe selects STORE over RECALL
  assign trig      = mem_sel & nv_mode & (wr_en | rd_en);
  assign start_ok  = trig & armed_q & ~busy;
  assign store_go  = start_ok & wr_en;
  assign recall_go = start_ok & ~wr_en;

  always_comb begin
    armed_d = armed_q;
    if (!trig) begin
      armed_d = 1'b1;
    end else if (start_ok) begin
      armed_d = 1'b0;
    end
    vld_d   = rd_req;
    rdata_d = rd_req ? work_rd_data : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      vld_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      armed_q <= armed_d;
      vld_q   <= vld_d;
      rdata_q <= rdata_d;
    end
  end

  assign rdata     = rdata_q;
  assign rdata_vld = vld_q;

endmodule

// File: rtl/ssr_xfer_seq.sv
module ssr_xfer_seq
  import ssr_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int STORE_WAIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              store_go,
  input  logic              recall_go,
  output xfer_state_e       state,
  output logic [ADDR_W-1:0] seq_addr,
  output logic              busy
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};
  localparam int                WAIT_W    = (STORE_WAIT > 1) ? $clog2(STORE_WAIT) : 1;
  localparam logic [WAIT_W-1:0] WAIT_END  = WAIT_W'((STORE_WAIT > 0) ? STORE_WAIT - 1 : 0);
  localparam xfer_state_e       AFTER_ST  = (STORE_WAIT > 0) ? XS_HOLD : XS_IDLE;

  xfer_state_e       state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d, addr_step;
  logic [WAIT_W-1:0] wait_q, wait_d;

  assign addr_step = addr_q + ADDR_W'(1);

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    wait_d  = wait_q;
    case (state_q)
      XS_IDLE: begin
        addr_d = '0;
        wait_d = '0;
        if (store_go) begin
          state_d = XS_STORE;
        end else if (recall_go) begin
          state_d = XS_CLEAR;
        end
      end
      XS_STORE: begin
        addr_d = addr_step;
        if (addr_q == LAST_ADDR) begin
          state_d = AFTER_ST;
          wait_d  = '0;
        end
      end
      XS_HOLD: begin
        if (wait_q == WAIT_END) begin
          state_d = XS_IDLE;
        end else begin
          wait_d = wait_q + WAIT_W'(1);
        end
      end
      XS_CLEAR: begin
        addr_d = addr_step;
        if (addr_q == LAST_ADDR) begin
          state_d = XS_LOAD;
        end
      end
      XS_LOAD: begin
        addr_d = addr_step;
        if (addr_q == LAST_ADDR) begin
          state_d = XS_IDLE;
        end
      end
      default: begin
        state_d = XS_IDLE;
      end
    endcase
  end

  // Reset lands in the clear pass: the power-up RECALL
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= XS_CLEAR;
      addr_q  <= '0;
      wait_q  <= '0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      wait_q  <= wait_d;
    end
  end

  assign state    = state_q;
  assign seq_addr = addr_q;
  assign busy     = (state_q != XS_IDLE);

endmodule

// File: rtl/shadowed_sram.sv
module shadowed_sram
  import ssr_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int DATA_W     = 8,
  parameter int STORE_WAIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mem_sel,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic              nv_mode,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rdata_vld,
  output logic              xfer_busy
);

  // Reset: asserted at once, released after two clock edges
  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  xfer_state_e       phase;
  logic [ADDR_W-1:0] seq_addr;
  logic              busy;
  logic              store_go, recall_go, sram_wr;

  logic              work_we;
  logic [ADDR_W-1:0] work_waddr, work_raddr;
  logic [DATA_W-1:0] work_wdata, work_rdata;
  logic              shadow_we;
  logic [DATA_W-1:0] shadow_rdata;

  ssr_bus_ctrl #(
    .DATA_W (DATA_W)
  ) u_bus (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .mem_sel      (mem_sel),
    .rd_en        (rd_en),
    .wr_en        (wr_en),
    .nv_mode      (nv_mode),
    .busy         (busy),
    .work_rd_data (work_rdata),
    .store_go     (store_go),
    .recall_go    (recall_go),
    .sram_wr      (sram_wr),
    .rdata        (bus_rdata),
    .rdata_vld    (bus_rdata_vld)
  );

  ssr_xfer_seq #(
    .ADDR_W     (ADDR_W),
    .STORE_WAIT (STORE_WAIT)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .store_go  (store_go),
    .recall_go (recall_go),
    .state     (phase),
    .seq_addr  (seq_addr),
    .busy      (busy)
  );

  // Working-array port selection
  always_comb begin
    work_we    = sram_wr;
    work_waddr = bus_addr;
    work_wdata = bus_wdata;
    work_raddr = bus_addr;
    if (busy) begin
      work_waddr = seq_addr;
      work_raddr = seq_addr;
    end
    case (phase)
      XS_CLEAR: begin
        work_we    = 1'b1;
        work_wdata = '0;
      end
      XS_LOAD: begin
        work_we    = 1'b1;
        work_wdata = shadow_rdata;
      end
      default: begin
      end
    endcase
  end

  assign shadow_we = (phase == XS_STORE);

  ssr_word_array #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_work (
    .clk     (clk),
    .wr_en   (work_we),
    .wr_addr (work_waddr),
    .wr_data (work_wdata),
    .rd_addr (work_raddr),
    .rd_data (work_rdata)
  );

  ssr_word_array #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_shadow (
    .clk     (clk),
    .wr_en   (shadow_we),
    .wr_addr (seq_addr),
    .wr_data (work_rdata),
    .rd_addr (seq_addr),
    .rd_data (shadow_rdata)
  );

  assign xfer_busy = busy;

endmodule

// File: rtl/ssr_checker.sv
module ssr_checker
  import ssr_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_sel,
  input logic              rd_en,
  input logic              wr_en,
  input logic              nv_mode,
  input logic              busy,
  input logic [DATA_W-1:0] rdata,
  input logic              rdata_vld,
  input logic              work_we,
  input logic [DATA_W-1:0] work_wdata,
  input logic              shadow_we,
  input logic [ADDR_W-1:0] seq_addr,
  input xfer_state_e       phase
);

  AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_sel && rd_en && !wr_en && !nv_mode && !busy) |=> rdata_vld); // R2

  AST_NV_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    nv_mode |=> !rdata_vld); // R3

  AST_NV_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_mode && !busy) |-> !work_we); // R3

  AST_START_ON_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(mem_sel && nv_mode && (wr_en || rd_en))); // R4

  AST_STORE_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (shadow_we && $past(shadow_we)) |-> (seq_addr == $past(seq_addr) + ADDR_W'(1))); // R4

  AST_CLEAR_WRITES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == XS_CLEAR) |-> (work_we && work_wdata == '0)); // R5

  AST_RECALL_KEEPS_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == XS_CLEAR || phase == XS_LOAD) |-> !shadow_we); // R6

  AST_SHADOW_IDLE_IN_SRAM: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !shadow_we); // R7

  AST_QUIET_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!rdata_vld && rdata == '0)); // R8

endmodule

bind shadowed_sram ssr_checker #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .mem_sel    (mem_sel),
  .rd_en      (rd_en),
  .wr_en      (wr_en),
  .nv_mode    (nv_mode),
  .busy       (xfer_busy),
  .rdata      (bus_rdata),
  .rdata_vld  (bus_rdata_vld),
  .work_we    (work_we),
  .work_wdata (work_wdata),
  .shadow_we  (shadow_we),
  .seq_addr   (seq_addr),
  .phase      (phase)
);

// File: tb/tb_shadowed_sram.sv
`timescale 1ns/1ps
module tb_shadowed_sram;

  localparam int STORE_WAIT = 16;
  localparam int WORDS      = 2048;
  localparam int ST_CYC     = WORDS + STORE_WAIT;
  localparam int RC_CYC     = 2 * WORDS;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mem_sel, rd_en, wr_en, nv_mode;
  logic [10:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic        bus_rdata_vld;
  logic        xfer_busy;

  always #4 clk = ~clk;

  shadowed_sram #(.STORE_WAIT(STORE_WAIT)) dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .mem_sel       (mem_sel),
    .rd_en         (rd_en),
    .wr_en         (wr_en),
    .nv_mode       (nv_mode),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .bus_rdata_vld (bus_rdata_vld),
    .xfer_busy     (xfer_busy)
  );

  int  n_checks = 0;
  int  n_errors = 0;
  bit  done     = 1'b0;

  // Model of the requirements: working and shadow contents of used words
  logic [7:0] wm [int];
  logic [7:0] sm [int];

  // Vector: op[20:19] (0 write, 1 read, 2 store, 3 recall), addr[18:8], data[7:0]
  localparam int NV = 16;
  localparam logic [20:0] VEC [NV] = '{
    {2'd0, 11'd0,    8'h11},
    {2'd0, 11'd1,    8'h22},
    {2'd0, 11'd2047, 8'h33},
    {2'd0, 11'd100,  8'h44},
    {2'd0, 11'd300,  8'h66},
    {2'd1, 11'd0,    8'h00},
    {2'd1, 11'd2047, 8'h00},
    {2'd2, 11'd0,    8'h00},
    {2'd0, 11'd0,    8'h55},
    {2'd1, 11'd0,    8'h00},
    {2'd3, 11'd0,    8'h00},
    {2'd1, 11'd0,    8'h00},
    {2'd1, 11'd1,    8'h00},
    {2'd1, 11'd100,  8'h00},
    {2'd1, 11'd2047, 8'h00},
    {2'd1, 11'd300,  8'h00}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_idle();
    mem_sel = 1'b0; rd_en = 1'b0; wr_en = 1'b0; nv_mode = 1'b0;
    bus_addr = '0; bus_wdata = '0;
  endtask

  task automatic do_write(input int a, input logic [7:0] d);
    @(negedge clk);
    mem_sel = 1'b1; wr_en = 1'b1; bus_addr = 11'(a); bus_wdata = d;
    @(negedge clk);
    bus_idle();
    wm[a] = d;
  endtask

  task automatic do_read(input int a, input string req);
    @(negedge clk);
    mem_sel = 1'b1; rd_en = 1'b1; bus_addr = 11'(a);
    @(negedge clk);
    check(bus_rdata_vld == 1'b1, req, int'(bus_rdata_vld), 1);
    check(bus_rdata == wm[a], req, int'(bus_rdata), int'(wm[a]));
    bus_idle();
  endtask

  task automatic wait_busy(output int n);
    n = 0;
    while (xfer_busy && n < 10000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic do_store();
    int n;
    @(negedge clk);
    mem_sel = 1'b1; wr_en = 1'b1; nv_mode = 1'b1;
    @(negedge clk);
    bus_idle();
    check(xfer_busy == 1'b1, "R4 store busy rise", int'(xfer_busy), 1);
    wait_busy(n);
    check(n == ST_CYC, "R4 store busy length", n, ST_CYC);
    sm = wm;
  endtask

  task automatic do_recall();
    int n;
    @(negedge clk);
    mem_sel = 1'b1; rd_en = 1'b1; nv_mode = 1'b1;
    @(negedge clk);
    bus_idle();
    check(xfer_busy == 1'b1, "R5 recall busy rise", int'(xfer_busy), 1);
    wait_busy(n);
    check(n == RC_CYC, "R5 recall busy length", n, RC_CYC);
    wm = sm;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    int n;
    bus_idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R11: state held in reset
    check(xfer_busy == 1'b1, "R11 busy in reset", int'(xfer_busy), 1);
    check(bus_rdata_vld == 1'b0, "R11 vld in reset", int'(bus_rdata_vld), 0);
    check(bus_rdata == 8'h00, "R11 rdata in reset", int'(bus_rdata), 0);

    // R10: power-up RECALL length, counted from release
    rst_n = 1'b1;
    wait_busy(n);
    check(n == RC_CYC + 2, "R10 auto recall length", n, RC_CYC + 2);

    // Vector walk: R1, R2, R4, R5, R7
    for (int i = 0; i < NV; i++) begin
      case (VEC[i][20:19])
        2'd0: do_write(int'(VEC[i][18:8]), VEC[i][7:0]);
        2'd1: do_read(int'(VEC[i][18:8]), "R1/R2/R5/R7 table read");
        2'd2: do_store();
        default: do_recall();
      endcase
    end

    // R2: no read strobe gives no valid data
    @(negedge clk);
    check(bus_rdata_vld == 1'b0 && bus_rdata == 8'h00, "R2 idle read port",
          int'(bus_rdata), 0);

    // R8: bus access during a STORE is ignored
    do_write(300, 8'h5A);
    @(negedge clk);
    mem_sel = 1'b1; wr_en = 1'b1; nv_mode = 1'b1;
    @(negedge clk);
    mem_sel = 1'b1; wr_en = 1'b1; nv_mode = 1'b0; bus_addr = 11'd300; bus_wdata = 8'hC3;
    @(negedge clk);
    mem_sel = 1'b1; wr_en = 1'b0; rd_en = 1'b1; bus_addr = 11'd300;
    @(negedge clk);
    check(bus_rdata_vld == 1'b0 && bus_rdata == 8'h00, "R8 read while busy",
          int'(bus_rdata_vld), 0);
    bus_idle();
    wait_busy(n);
    sm = wm;
    do_read(300, "R8 write while busy ignored");

    // R9 and R3: hold STORE trigger through the whole transfer
    do_write(1, 8'h77);
    @(negedge clk);
    mem_sel = 1'b1; wr_en = 1'b1; nv_mode = 1'b1; bus_addr = 11'd1; bus_wdata = 8'hEE;
    @(negedge clk);
    wait_busy(n);
    sm = wm;
    repeat (5) @(negedge clk);
    check(xfer_busy == 1'b0, "R9 held trigger no restart", int'(xfer_busy), 0);
    bus_idle();
    do_read(1, "R3 nv-mode write blocked");
    @(negedge clk);
    mem_sel = 1'b1; rd_en = 1'b1; nv_mode = 1'b1;
    @(negedge clk);
    check(xfer_busy == 1'b1, "R9 rearmed trigger starts", int'(xfer_busy), 1);
    bus_idle();
    wait_busy(n);
    wm = sm;

    // R6: repeated RECALLs give identical contents
    do_write(0, 8'hA1);
    do_recall();
    do_read(0, "R6 first recall");
    do_recall();
    do_read(0, "R6 second recall");
    do_read(1, "R6 second recall other word");

    // R10: reset brings back stored data, not newer writes
    do_write(2047, 8'h9C);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    wait_busy(n);
    check(n == RC_CYC + 2, "R10 auto recall after reset", n, RC_CYC + 2);
    wm = sm;
    do_read(2047, "R10 stored data restored");
    do_read(100, "R10 stored data restored");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule